// File: doc/BRIEF.md
# Serial Port Register Block

This block presents a serial port to a processor as a small bank of 32-bit word registers. Received characters arrive as whole bytes through a valid/ready handshake and are queued in a 16-entry circular buffer. The processor drains that buffer through one of two status words: one only looks at the oldest byte, the other also removes it. Writing the data-out word sends its low byte out as a one-cycle strobe. Interrupt sources are kept in a raw register, gated by a mask, and cleared by writing ones to an acknowledge word.

The transmit-done source has one unusual rule. The first acknowledge after a transmit never clears bit 0, so software that acknowledges everything at once still sees that bit until it acknowledges a second time. All accesses are full 32-bit words. A read and a write never share a cycle; if both strobes are high, only the write takes place.

Top module: `serport_regs`

## Requirements
- R1: After reset, word 2 (receive control) reads 0x00010000. Every other stored word and the raw interrupt word read 0. `irq` and `rx_ready` are low.
- R2: A write to any word other than 8, 9, 12, 13 and 14 stores the full 32-bit value, and a later read returns it unchanged. This includes unlisted words such as 4 and 15, and word 7 (data out).
- R3: Words 8 and 9 both read as follows: bit 24 = 1, bit 22 = 1, bit 16 = buffer holds data, bits 7:0 = the byte at the read slot, all other bits 0. The read slot is the write position minus the fill count, modulo 16; it holds the oldest byte whenever the buffer is not empty.
- R4: A read of word 8 with a non-empty buffer removes the oldest byte. A read of word 9, or of word 8 with an empty buffer, leaves the fill count unchanged.
- R5: `rx_ready` is high exactly when bit 3 of word 2 is 1 and fewer than 16 bytes are queued. Accepted bytes come back out in arrival order.
- R6: A byte offered while the buffer is full is not stored. The 16 queued bytes are unaffected.
- R7: Bit 3 of the raw interrupt word (word 13) is 1 exactly when the buffer is not empty. This holds whatever value is written to words 12 or 13.
- R8: Word 14 reads raw AND mask (mask is word 11). `irq` is high when any bit of word 14 is 1.
- R9: A write to word 7 makes `tx_strobe` high for the next cycle only, with `tx_data` equal to bits 7:0 of the written value. It also sets raw bits 0 and 1 and marks a transmit as pending.
- R10: A write to word 12 clears every raw bit written as 1. If a transmit is pending, bit 0 is first removed from the value, and the pending mark is cleared. Word 12 reads back the value actually applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; a read of word 8 pops at the clock edge |
| bus_addr | input | 4 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, high when any masked bit is 1 |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | Block can accept a byte |
| tx_data | output | 8 | Transmitted byte |
| tx_strobe | output | 1 | One-cycle pulse with a new `tx_data` |

## Verification
The hardest state to reach is a full buffer while a further byte is still being offered. The stimulus first enables the receiver, then pushes sixteen distinct bytes and holds `rx_valid` with a seventeenth. It then pops everything and checks the order, and confirms that a pop on an empty buffer changes nothing. The second hard case is the pending-transmit exception. This needs a data-out write followed by two acknowledges of bit 0, reading the raw and acknowledge words between them.

// File: rtl/serport_regs.sv
module serport_regs #(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_strobe
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [3:0] A_RXCTL = 4'd2,  A_DOUT = 4'd7,  A_POP  = 4'd8,
                         A_PEEK  = 4'd9,  A_MASK = 4'd11, A_ACK  = 4'd12,
                         A_RAW   = 4'd13, A_MSKD = 4'd14;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] regs [16];
  logic [7:0]    mem  [DEPTH];
  logic [AW-1:0] wpos;
  logic [CW-1:0] count;
  logic [DW-1:4] raw_hi;
  logic [2:0]    raw_lo;
  logic          pending;

  logic          nonempty, push, pop, wr_dout, wr_ack;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] raw, masked, ack_val, status;

  assign nonempty = count != '0;
  assign rd_idx   = wpos - count[AW-1:0];
  assign rx_ready = regs[A_RXCTL][3] && count != FULL;
  assign push     = rx_valid && rx_ready;
  assign pop      = bus_rd && !bus_wr && bus_addr == A_POP && nonempty;
  assign wr_dout  = bus_wr && bus_addr == A_DOUT;
  assign wr_ack   = bus_wr && bus_addr == A_ACK;
  assign raw      = {raw_hi, nonempty, raw_lo};
  assign masked   = raw & regs[A_MASK];
  assign irq      = |masked;
  assign ack_val  = pending ? (bus_wdata & ~DW'(1)) : bus_wdata;
  assign status   = {7'd0, 1'b1, 1'b0, 1'b1, 5'd0, nonempty, 8'd0, mem[rd_idx]};

  always_comb begin
    case (bus_addr)
      A_POP, A_PEEK: bus_rdata = status;
      A_RAW:         bus_rdata = raw;
      A_MSKD:        bus_rdata = masked;
      default:       bus_rdata = regs[bus_addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= '0;
      regs[A_RXCTL] <= 32'h0001_0000;
      raw_hi    <= '0;
      raw_lo    <= '0;
      pending   <= 1'b0;
      tx_strobe <= 1'b0;
      tx_data   <= '0;
    end else begin
      tx_strobe <= wr_dout;
      if (wr_dout) tx_data <= bus_wdata[7:0];
      if (bus_wr) begin
        if (wr_ack) begin
          regs[A_ACK] <= ack_val;
          raw_hi      <= raw_hi & ~ack_val[DW-1:4];
          raw_lo      <= raw_lo & ~ack_val[2:0];
          pending     <= 1'b0;
        end else if (bus_addr == A_RAW) begin
          raw_hi <= bus_wdata[DW-1:4];
          raw_lo <= bus_wdata[2:0];
        end else begin
          regs[bus_addr] <= bus_wdata;
        end
        if (wr_dout) begin
          raw_lo[1:0] <= 2'b11;
          pending     <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wpos] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos  <= '0;
      count <= '0;
    end else begin
      if (push) wpos <= wpos + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL) |-> !rx_ready);
  a_r4_pop_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count == $past(count) - 1'b1);
  a_r4_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == A_PEEK && !push) |=> $stable(count));
  a_r9_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(wr_dout));
  a_r9_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> raw[1:0] == 2'b11 && pending);
  a_r10_pending_spares: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && pending) |=> !pending && raw[0] == $past(raw[0]));
  a_r8_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK && bus_wdata == '0) |=> !irq);
endmodule

// File: tb/serport_regs_test.sv
module serport_regs_test;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, rx_valid = 0, rx_ready, tx_strobe;
  logic [7:0] rx_data = 0, tx_data;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  serport_regs uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_strobe(tx_strobe));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic offer(logic [7:0] b, output logic rdy);
    @(negedge clk); rx_valid = 1; rx_data = b; #1 rdy = rx_ready;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'd2, d);  chk("R1 rxctl", d, 32'h0001_0000);
    rd(4'd0, d);  chk("R1 word0", d, 0);
    rd(4'd13, d); chk("R1 raw", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rx_ready", rx_ready, 0);
  endtask

  task automatic t_store;
    logic [31:0] d;
    wr(4'd4, 32'hDEAD_BEEF);  rd(4'd4, d);  chk("R2 word4", d, 32'hDEAD_BEEF);
    wr(4'd15, 32'h1234_5678); rd(4'd15, d); chk("R2 word15", d, 32'h1234_5678);
    wr(4'd1, 32'h0000_00FF);  rd(4'd1, d);  chk("R2 word1", d, 32'h0000_00FF);
  endtask

  task automatic t_rx;
    logic [31:0] d; logic r;
    offer(8'h55, r); chk("R5 disabled", r, 0);
    rd(4'd9, d); chk("R6 no store when disabled", d[16], 0);
    wr(4'd2, 32'h0001_0008);
    for (int i = 0; i < 16; i++) begin
      offer(8'h10 + 8'(i), r); chk("R5 ready", r, 1);
    end
    chk("R5 full not ready", rx_ready, 0);
    offer(8'hEE, r); chk("R6 full offer", r, 0);
    rd(4'd9, d); chk("R3 peek", d, 32'h0141_0010);
    rd(4'd9, d); chk("R4 peek keeps", d, 32'h0141_0010);
    rd(4'd13, d); chk("R7 raw nonempty", d[3], 1);
    wr(4'd12, 32'h0000_0008); rd(4'd13, d); chk("R7 ack no effect", d[3], 1);
    for (int i = 0; i < 16; i++) begin
      rd(4'd8, d); chk("R4 pop order", d, 32'h0141_0010 + 32'(i));
    end
    rd(4'd9, d); chk("R6 empty after 16", d & 32'hFFFF_FF00, 32'h0140_0000);
    chk("R5 ready again", rx_ready, 1);
    rd(4'd8, d); rd(4'd9, d); chk("R4 empty pop", d & 32'hFFFF_FF00, 32'h0140_0000);
    rd(4'd13, d); chk("R7 raw empty", d[3], 0);
  endtask

  task automatic t_irq;
    logic [31:0] d; logic r;
    wr(4'd11, 32'h0000_0008);
    chk("R8 irq empty", irq, 0);
    offer(8'hA7, r);
    #1 chk("R8 irq set", irq, 1);
    rd(4'd14, d); chk("R8 masked", d, 32'h8);
    rd(4'd8, d); chk("R3 pop byte", d, 32'h0141_00A7);
    chk("R8 irq clear", irq, 0);
    wr(4'd11, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    @(negedge clk); bus_wr = 1; bus_addr = 4'd7; bus_wdata = 32'h0000_01A5;
    @(posedge clk); #1 bus_wr = 0;
    chk("R9 strobe", tx_strobe, 1);
    chk("R9 data", tx_data, 8'hA5);
    @(posedge clk); #1 chk("R9 strobe one cycle", tx_strobe, 0);
    rd(4'd13, d); chk("R9 raw bits", d, 32'h3);
    rd(4'd7, d);  chk("R2 dout stored", d, 32'h0000_01A5);
    wr(4'd11, 32'h1); chk("R8 irq tx", irq, 1);
    wr(4'd12, 32'h3);
    rd(4'd13, d); chk("R10 first ack keeps bit0", d, 32'h1);
    rd(4'd12, d); chk("R10 ack readback", d, 32'h2);
    wr(4'd12, 32'h1);
    rd(4'd13, d); chk("R10 second ack", d, 32'h0);
    chk("R8 irq off", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_store();
    t_rx();
    t_irq();
    t_tx();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule